// File: doc/BRIEF.md
# Expansion Slot Control Register Block

This block sits in a host bridge that serves six expansion-bus option slots. Software reaches two registers over a simple single-cycle register bus. One is a slot configuration register holding a three-bit field per slot. The other is an interrupt mask register with one bit per slot. A third, read/clear status register reports bus parity errors.

From the stored fields the block makes the per-slot control decisions and presents them as registered enables.

- Parity is checked on incoming cycles from enabled slots.
- A per-slot bit chooses whether DMA from that slot goes through the scatter/gather map.
- A per-slot bit allows the special block-style write.
- Slot interrupt requests pass through the mask, giving a masked vector and one combined request.

The block also watches the bus. While the host drives, it produces the parity bit for the word. While an option drives, it checks that option's parity when the option's slot has checking enabled. A failure sets a sticky flag and records the slot that caused it.

Register map (word address on `reg_addr`):

| Address | Register |
|---------|----------|
| 0 | slot configuration |
| 1 | interrupt mask |
| 2 | parity status |

Any other address reads as zero and ignores writes.

Top module: `slot_ctl_regs`

## Requirements
- R1: After reset:
  - the configuration register reads 0;
  - the interrupt mask reads all ones (0x3F);
  - the parity status reads 0;
  - all per-slot enables are 0;
  - `irq_masked` and `irq_any` are 0.
- R2: Slot n owns configuration bits 3n+2 down to 3n, with the parity-check enable at 3n+2, block-write enable at 3n+1 and scatter/gather enable at 3n. Each bit appears on the matching bit n of `par_chk_en`, `blk_mode_en` and `sg_en` from the cycle after the write.
- R3: A read returns data on `reg_rdata` one cycle after `reg_rd_en`.
  - Bits above 17 of the configuration register read 0, and bits above 5 of the mask read 0.
  - Writes to those bits have no effect.
  - An unmapped address reads 0.
- R4: Parity is checked only on a cycle with `bus_valid`=1, `bus_host_drive`=0, `bus_slot` below 6 and that slot's parity enable set. The check is even parity: the XOR of `bus_data` and `bus_parity` must be 0.
- R5: `host_parity` is the XOR of all 32 bits of `bus_data`, registered one cycle, whatever the configuration. A cycle driven by the host never raises a parity error.
- R6: A failed check sets `par_err` and stores the slot in `par_err_slot`.
  - Status register layout: bit 0 is the flag and bits 10:8 are the slot.
  - Later failures keep the first slot until software clears.
  - Writing 1 to status bit 0 clears both; writing 0 does nothing.
  - A failure in the same cycle as a clear wins and records its own slot.
- R7: A mask bit of 1 blocks that slot's request and 0 passes it. `irq_masked` equals `irq_raw` AND NOT mask, and `irq_any` is the OR of `irq_masked`, both one cycle after the inputs.
- R8: `dma_use_map` is, one cycle later, the scatter/gather enable of the slot on `dma_slot`. It is 0 for slot numbers 6 and 7.
- R9: The block-write enable bits affect no output other than `blk_mode_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd_en` |
| bus_valid | input | 1 | A bus data cycle is in progress |
| bus_host_drive | input | 1 | 1 = host drives the bus, 0 = an option drives |
| bus_slot | input | 3 | Slot taking part in the cycle |
| bus_data | input | 32 | Bus data word |
| bus_parity | input | 1 | Parity bit driven with the word |
| host_parity | output | 1 | Even parity bit for the current word, registered |
| par_err | output | 1 | Sticky parity-error flag |
| par_err_slot | output | 3 | Slot of the first recorded parity error |
| par_chk_en | output | 6 | Per-slot parity-check enable |
| blk_mode_en | output | 6 | Per-slot block-write enable |
| sg_en | output | 6 | Per-slot scatter/gather enable |
| dma_slot | input | 3 | Slot of the current DMA request |
| dma_use_map | output | 1 | DMA request is routed through the scatter/gather map |
| irq_raw | input | 6 | Raw slot interrupt requests |
| irq_masked | output | 6 | Requests after masking |
| irq_any | output | 1 | OR of the masked requests |

## Verification
Every register in this block drives a port within one cycle, so a corrupted stored bit shows up on the next edge.

- A bad configuration field shows on the enable vectors.
- A bad mask bit shows on `irq_masked` as soon as the matching request is raised.
- A bad sticky flag or slot shows on `par_err` and `par_err_slot`.

The harder faults are ones that show only under a specific stimulus:

- a check made on a host-driven cycle or for a disabled slot;
- a first slot that a later error overwrites;
- a clear that beats a same-cycle error.

Each needs a chosen cycle to make the flag or slot differ at the next edge.

// File: rtl/slot_ctl_pkg.sv
package slot_ctl_pkg;
  // per-slot field layout inside the configuration register
  localparam int unsigned FIELD_W   = 3;
  localparam int unsigned FIELD_PAR = 2;
  localparam int unsigned FIELD_BLK = 1;
  localparam int unsigned FIELD_SG  = 0;

  // register word addresses
  localparam int unsigned ADDR_CFG  = 0;
  localparam int unsigned ADDR_MASK = 1;
  localparam int unsigned ADDR_STAT = 2;

  // status register layout
  localparam int unsigned STAT_FLAG_BIT = 0;
  localparam int unsigned STAT_SLOT_LSB = 8;
endpackage

// File: rtl/slot_cfg_regfile.sv
module slot_cfg_regfile
  import slot_ctl_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 6,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SLOT_W    = 3,
  localparam int unsigned CFG_W    = NUM_SLOTS * FIELD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 err_flag,
  input  logic [SLOT_W-1:0]    err_slot,
  output logic [DATA_W-1:0]    rdata,
  output logic [CFG_W-1:0]     cfg_q,
  output logic [NUM_SLOTS-1:0] mask_q,
  output logic                 stat_clr
);
  logic              sel_cfg, sel_mask, sel_stat;
  logic [DATA_W-1:0] rd_word;
  logic              unused_wdata;

  assign sel_cfg  = (addr == ADDR_W'(ADDR_CFG));
  assign sel_mask = (addr == ADDR_W'(ADDR_MASK));
  assign sel_stat = (addr == ADDR_W'(ADDR_STAT));

  // bits above the configuration field are discarded
  assign unused_wdata = ^wdata;

  assign stat_clr = wr_en && sel_stat && wdata[STAT_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      mask_q <= '1;
    end else if (wr_en) begin
      if (sel_cfg)  cfg_q  <= wdata[CFG_W-1:0];
      if (sel_mask) mask_q <= wdata[NUM_SLOTS-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    if (sel_cfg) begin
      rd_word[CFG_W-1:0] = cfg_q;
    end else if (sel_mask) begin
      rd_word[NUM_SLOTS-1:0] = mask_q;
    end else if (sel_stat) begin
      rd_word[STAT_FLAG_BIT]            = err_flag;
      rd_word[STAT_SLOT_LSB +: SLOT_W]  = err_slot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_word;
    end
  end
endmodule

// File: rtl/slot_parity_mon.sv
module slot_parity_mon #(
  parameter int unsigned NUM_SLOTS = 6,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SLOT_W    = 3,
  localparam int unsigned SLOT_CNT = 1 << SLOT_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_valid,
  input  logic                 host_drive,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [DATA_W-1:0]    data,
  input  logic                 par_in,
  input  logic [NUM_SLOTS-1:0] chk_en,
  input  logic                 clr,
  output logic                 err_q,
  output logic [SLOT_W-1:0]    err_slot_q,
  output logic                 host_par_q
);
  logic [SLOT_CNT-1:0] chk_en_pad;
  logic                checked, mismatch;

  // slot numbers past the last slot see a zero enable
  assign chk_en_pad = SLOT_CNT'(chk_en);
  assign checked    = bus_valid && !host_drive && chk_en_pad[slot];
  assign mismatch   = ^{data, par_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      host_par_q <= 1'b0;
    end else begin
      host_par_q <= ^data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q      <= 1'b0;
      err_slot_q <= '0;
    end else if (checked && mismatch) begin
      if (!err_q || clr) begin
        err_q      <= 1'b1;
        err_slot_q <= slot;
      end
    end else if (clr) begin
      err_q      <= 1'b0;
      err_slot_q <= '0;
    end
  end
endmodule

// File: rtl/slot_irq_gate.sv
module slot_irq_gate #(
  parameter int unsigned NUM_SLOTS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] raw,
  input  logic [NUM_SLOTS-1:0] mask,
  output logic [NUM_SLOTS-1:0] masked_q,
  output logic                 any_q
);
  logic [NUM_SLOTS-1:0] pass;

  assign pass = raw & ~mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      masked_q <= '0;
      any_q    <= 1'b0;
    end else begin
      masked_q <= pass;
      any_q    <= |pass;
    end
  end
endmodule

// File: rtl/slot_ctl_regs.sv
module slot_ctl_regs
  import slot_ctl_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 6,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
  localparam int unsigned SLOT_CNT = 1 << SLOT_W,
  localparam int unsigned CFG_W    = NUM_SLOTS * FIELD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_en,
  input  logic                 reg_rd_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 bus_valid,
  input  logic                 bus_host_drive,
  input  logic [SLOT_W-1:0]    bus_slot,
  input  logic [DATA_W-1:0]    bus_data,
  input  logic                 bus_parity,
  output logic                 host_parity,
  output logic                 par_err,
  output logic [SLOT_W-1:0]    par_err_slot,
  output logic [NUM_SLOTS-1:0] par_chk_en,
  output logic [NUM_SLOTS-1:0] blk_mode_en,
  output logic [NUM_SLOTS-1:0] sg_en,
  input  logic [SLOT_W-1:0]    dma_slot,
  output logic                 dma_use_map,
  input  logic [NUM_SLOTS-1:0] irq_raw,
  output logic [NUM_SLOTS-1:0] irq_masked,
  output logic                 irq_any
);
  logic [CFG_W-1:0]     cfg_q;
  logic [NUM_SLOTS-1:0] mask_q;
  logic                 stat_clr;
  logic [SLOT_CNT-1:0]  sg_pad;
  logic                 dma_map_q;

  slot_cfg_regfile #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata),
    .err_flag(par_err), .err_slot(par_err_slot),
    .rdata(reg_rdata), .cfg_q(cfg_q), .mask_q(mask_q), .stat_clr(stat_clr)
  );

  // unpack each slot field into the per-slot enable vectors
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign par_chk_en[s]  = cfg_q[s*FIELD_W + FIELD_PAR];
    assign blk_mode_en[s] = cfg_q[s*FIELD_W + FIELD_BLK];
    assign sg_en[s]       = cfg_q[s*FIELD_W + FIELD_SG];
  end

  slot_parity_mon #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .SLOT_W(SLOT_W)
  ) par_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .host_drive(bus_host_drive),
    .slot(bus_slot), .data(bus_data), .par_in(bus_parity),
    .chk_en(par_chk_en), .clr(stat_clr),
    .err_q(par_err), .err_slot_q(par_err_slot), .host_par_q(host_parity)
  );

  slot_irq_gate #(.NUM_SLOTS(NUM_SLOTS)) irq_i (
    .clk(clk), .rst(rst), .raw(irq_raw), .mask(mask_q),
    .masked_q(irq_masked), .any_q(irq_any)
  );

  // DMA routing: slot numbers past the last slot map to direct addressing
  assign sg_pad = SLOT_CNT'(sg_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_map_q <= 1'b0;
    end else begin
      dma_map_q <= sg_pad[dma_slot];
    end
  end

  assign dma_use_map = dma_map_q;
endmodule

// File: rtl/slot_ctl_regs_chk.sv
module slot_ctl_regs_chk #(
  parameter int unsigned NUM_SLOTS = 6,
  parameter int unsigned SLOT_W    = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_valid,
  input logic                 bus_host_drive,
  input logic [SLOT_W-1:0]    dma_slot,
  input logic                 dma_use_map,
  input logic [NUM_SLOTS-1:0] irq_masked,
  input logic                 irq_any,
  input logic                 par_err,
  input logic [SLOT_W-1:0]    par_err_slot,
  input logic                 stat_clr
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (irq_masked == '0 && !irq_any && !par_err));

  // R7
  irq_any_chk: assert property (@(posedge clk) disable iff (rst)
    irq_any == (|irq_masked));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (par_err && !stat_clr) |=> par_err);

  // R6
  err_slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (par_err && !stat_clr) |=> $stable(par_err_slot));

  // R4
  no_check_unless_option_chk: assert property (@(posedge clk) disable iff (rst)
    (!par_err && !(bus_valid && !bus_host_drive)) |=> !par_err);

  // R8
  dma_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(dma_slot) >= NUM_SLOTS) |=> !dma_use_map);
endmodule

bind slot_ctl_regs slot_ctl_regs_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) chk_i (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_host_drive(bus_host_drive),
  .dma_slot(dma_slot), .dma_use_map(dma_use_map),
  .irq_masked(irq_masked), .irq_any(irq_any),
  .par_err(par_err), .par_err_slot(par_err_slot), .stat_clr(stat_clr)
);

// File: tb/slot_ctl_regs_tb.sv
module slot_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        bus_valid = 1'b0, bus_host_drive = 1'b0, bus_parity = 1'b0;
  logic [2:0]  bus_slot = '0, dma_slot = '0;
  logic [31:0] bus_data = '0;
  logic        host_parity, par_err, dma_use_map, irq_any;
  logic [2:0]  par_err_slot;
  logic [5:0]  par_chk_en, blk_mode_en, sg_en, irq_masked;
  logic [5:0]  irq_raw = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  slot_ctl_regs dut_i (.*);

  // {mask, raw, expected masked}
  localparam logic [17:0] IRQ_VEC [8] = '{
    {6'h3F, 6'h3F, 6'h00}, {6'h00, 6'h3F, 6'h3F},
    {6'h2A, 6'h3F, 6'h15}, {6'h15, 6'h0F, 6'h0A},
    {6'h0F, 6'h30, 6'h30}, {6'h3E, 6'h01, 6'h01},
    {6'h1F, 6'h20, 6'h20}, {6'h00, 6'h00, 6'h00}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic bus_cycle(logic host, logic [2:0] s, logic [31:0] d, logic p);
    @(negedge clk);
    bus_valid = 1'b1; bus_host_drive = host; bus_slot = s; bus_data = d; bus_parity = p;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    irq_raw = 6'h3F;
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_masked", 32'(irq_masked), 32'h0);
    check("R1 enables", 32'({par_chk_en, blk_mode_en, sg_en}), 32'h0);
    reg_read(4'd0, rv); check("R1 cfg", rv, 32'h0);
    reg_read(4'd1, rv); check("R1 mask", rv, 32'h3F);
    reg_read(4'd2, rv); check("R1 stat", rv, 32'h0);
    check("R1 irq_masked after edges", 32'(irq_masked), 32'h0);

    // R7 vector table
    for (int i = 0; i < 8; i++) begin
      reg_write(4'd1, {26'h0, IRQ_VEC[i][17:12]});
      @(negedge clk);
      irq_raw = IRQ_VEC[i][11:6];
      @(negedge clk);
      check("R7 irq_masked", 32'(irq_masked), 32'(IRQ_VEC[i][5:0]));
      check("R7 irq_any", 32'(irq_any), 32'(IRQ_VEC[i][5:0] != 6'h0));
    end

    // R3 unused bits, unmapped address
    reg_write(4'd1, 32'hFFFF_FFC5);
    reg_read(4'd1, rv); check("R3 mask upper bits", rv, 32'h05);
    reg_write(4'd0, 32'hFFFC_0540);
    reg_read(4'd0, rv); check("R3 cfg upper bits", rv, 32'h540);
    reg_write(4'd3, 32'hFFFF_FFFF);
    reg_read(4'd3, rv); check("R3 unmapped", rv, 32'h0);
    reg_read(4'd0, rv); check("R3 cfg after unmapped write", rv, 32'h540);

    // R2 field layout, R9 block bit only on its own output
    check("R2 par_chk_en", 32'(par_chk_en), 32'h04);
    check("R2 sg_en", 32'(sg_en), 32'h04);
    check("R9 blk_mode_en", 32'(blk_mode_en), 32'h08);

    // R8 DMA routing
    @(negedge clk); dma_slot = 3'd2;
    @(negedge clk); check("R8 slot2 map", 32'(dma_use_map), 32'h1);
    dma_slot = 3'd3;
    @(negedge clk); check("R9 slot3 block-only no map", 32'(dma_use_map), 32'h0);
    dma_slot = 3'd7;
    @(negedge clk); check("R8 slot7 out of range", 32'(dma_use_map), 32'h0);

    // R5 host parity generation
    bus_cycle(1'b1, 3'd0, 32'h7, 1'b0);
    check("R5 host parity odd word", 32'(host_parity), 32'h1);
    bus_cycle(1'b1, 3'd0, 32'h3, 1'b0);
    check("R5 host parity even word", 32'(host_parity), 32'h0);

    // R4 checks only for enabled option-driven slot
    bus_cycle(1'b0, 3'd1, 32'h1, 1'b0);
    check("R4 disabled slot ignored", 32'(par_err), 32'h0);
    bus_cycle(1'b1, 3'd2, 32'h1, 1'b0);
    check("R5 host cycle not checked", 32'(par_err), 32'h0);
    bus_cycle(1'b0, 3'd2, 32'h3, 1'b0);
    check("R4 good parity", 32'(par_err), 32'h0);
    bus_cycle(1'b0, 3'd2, 32'h1, 1'b0);
    check("R4 bad parity flagged", 32'(par_err), 32'h1);
    check("R6 err slot", 32'(par_err_slot), 32'h2);
    reg_read(4'd2, rv); check("R6 stat read", rv, 32'h201);

    // R6 first slot kept, clear behaviour
    reg_write(4'd0, 32'h0002_0540);
    bus_cycle(1'b0, 3'd5, 32'h1, 1'b0);
    reg_read(4'd2, rv); check("R6 first slot kept", rv, 32'h201);
    reg_write(4'd2, 32'h0);
    reg_read(4'd2, rv); check("R6 write 0 no clear", rv, 32'h201);
    reg_write(4'd2, 32'h1);
    reg_read(4'd2, rv); check("R6 cleared", rv, 32'h0);
    @(negedge clk);
    bus_valid = 1'b1; bus_host_drive = 1'b0; bus_slot = 3'd5; bus_data = 32'h1; bus_parity = 1'b0;
    reg_wr_en = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h1;
    @(negedge clk);
    bus_valid = 1'b0; reg_wr_en = 1'b0;
    check("R6 error beats clear", 32'({par_err, par_err_slot}), 32'hD);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule